// File: doc/BRIEF.md
# Start-Stop Link Delay Timer

This block measures how long a word takes to cross a serial link. The measurement is counted in whole 20-bit word periods and then refined to single bit times. On the transmit side it supplies a steady idle stream. Each idle word is one pair of code-groups: a comma followed by a data group. When software-independent control logic pulses the start input, one idle pair is swapped for a marker pair and a cycle counter begins. On the receive side the block watches the aligned and decoded word stream. When the marker pair comes back, the count is frozen. The frozen count is then combined with the aligner's bit-slip position, which gives a fine result in units of one bit time. At 3.125 Gbps one word is 6.4 ns and one bit is 320 ps.

Both word streams use valid/ready. The transmit stream is always valid once reset has ended, and a word is only consumed in a cycle where ready is high. While ready is low the same word is held, so back-pressure stalls the stream without losing or duplicating anything. The receive side drives ready high from the first cycle after reset and never stalls the link. The serializer, the line codec and the medium sit outside this block. Start is a one-cycle control pulse, and busy, done and overflow are plain levels.

Top module: `linkdly_timer`

## Requirements
- R1: Every transmitted word other than the marker is the idle pair. The first code-group sits in bits 7:0 and is the comma 0xBC, with its control flag in bit 0 of the flag pair set. The second sits in bits 15:8 and is the data value 0x50, with its flag in bit 1 clear.
- R2: Reset drives busy, done, overflow, the coarse result and the fine result to zero. From the first cycle after reset, tx_valid and rx_ready are both high.
- R3: While tx_valid is high and tx_ready is low, tx_data and tx_isk hold their value. The marker's launch time is the cycle in which it is handed over (valid and ready both high).
- R4: A start pulse while busy is low is accepted, and busy rises in the next cycle. Exactly one marker pair is then sent, with 0xF7 and its flag set in the first code-group and MARK_DATA with its flag clear in the second. Idle pairs follow it.
- R5: A start pulse while busy is high is ignored. No second marker is sent, and the running measurement finishes with an unchanged result.
- R6: The stop event is a received word, accepted while the counter runs, that has 0xF7 with its flag set in bits 7:0 and a clear flag for bits 15:8. The coarse result is the number of clock cycles from the marker's launch to that word. A marker received while no measurement runs changes nothing.
- R7: The fine result equals coarse × 20 plus the slip value present in the stop cycle. The slip value must be in the range 0 to 19.
- R8: The counter saturates at 2^CNT_W − 1 rather than wrapping, and overflow is then set. Overflow stays set until the next accepted start.
- R9: Done rises in the cycle after the stop event, and busy falls at the same edge. Done stays high and busy stays low until the next accepted start, which clears done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to launch a marker |
| slip_i | input | 5 | Bit-slip position of the receive aligner, 0..19 |
| tx_data | output | 16 | Transmit pair, first code-group in bits 7:0 |
| tx_isk | output | 2 | Control flags of the transmit pair |
| tx_valid | output | 1 | Transmit word valid |
| tx_ready | input | 1 | Link accepts the transmit word |
| rx_data | input | 16 | Decoded, aligned receive pair |
| rx_isk | input | 2 | Control flags of the receive pair |
| rx_valid | input | 1 | Receive word valid |
| rx_ready | output | 1 | Block accepts the receive word |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | Result available |
| overflow | output | 1 | Counter saturated during the last measurement |
| coarse | output | CNT_W | Delay in word periods |
| fine | output | CNT_W+5 | Delay in bit times |

## Verification
The checks assume that the slip input always stays below 20. They also assume the link carries the marker back at least one cycle after it leaves, so launch and stop never fall in the same cycle. The bench models the link as a ring of recorded hand-overs read back a fixed number of cycles later, with that delay always one or more. It draws the slip values from 0 to 19 only. It clears the ring whenever the delay changes, so a stale marker from an earlier run cannot arrive in the middle of a new one. Random back-pressure on tx_ready exercises the hold rule, and the bench also injects stray markers while the block is idle.

// File: rtl/linkdly_pkg.sv
package linkdly_pkg;
  localparam int GRP_W       = 8;
  localparam int PAIR_W      = 2 * GRP_W;
  localparam int SLIP_W      = 5;
  localparam int UI_PER_WORD = 20;

  localparam logic [GRP_W-1:0] COMMA_K   = 8'hBC;
  localparam logic [GRP_W-1:0] IDLE_D    = 8'h50;
  localparam logic [GRP_W-1:0] MARKER_K  = 8'hF7;

  typedef struct packed {
    logic [1:0]        isk;
    logic [PAIR_W-1:0] data;
  } pair_t;

  function automatic pair_t idle_pair();
    pair_t p;
    p.isk  = 2'b01;
    p.data = {IDLE_D, COMMA_K};
    return p;
  endfunction

  function automatic pair_t marker_pair(input logic [GRP_W-1:0] tag);
    pair_t p;
    p.isk  = 2'b01;
    p.data = {tag, MARKER_K};
    return p;
  endfunction

  function automatic logic is_marker(input pair_t p);
    return (p.isk == 2'b01) && (p.data[GRP_W-1:0] == MARKER_K);
  endfunction
endpackage

// File: rtl/ld_tx_gen.sv
module ld_tx_gen
  import linkdly_pkg::*;
#(
  parameter logic [7:0] MARK_DATA = 8'h4A
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  arm,
  input  logic  tx_ready,
  output pair_t tx_word,
  output logic  tx_valid,
  output logic  mark_sent
);
  logic pend;
  logic cur_mark;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_word  <= idle_pair();
      pend     <= 1'b0;
      cur_mark <= 1'b0;
    end else begin
      if (arm) pend <= 1'b1;
      if (!tx_valid || tx_ready) begin
        tx_valid <= 1'b1;
        if (pend) begin
          tx_word  <= marker_pair(MARK_DATA);
          cur_mark <= 1'b1;
          pend     <= 1'b0;
        end else begin
          tx_word  <= idle_pair();
          cur_mark <= 1'b0;
        end
      end
    end
  end

  assign mark_sent = tx_valid && tx_ready && cur_mark;
endmodule

// File: rtl/ld_rx_det.sv
module ld_rx_det
  import linkdly_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  pair_t rx_word,
  input  logic  rx_valid,
  input  logic  armed,
  output logic  rx_ready,
  output logic  hit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_ready <= 1'b0;
    else        rx_ready <= 1'b1;
  end

  assign hit = rx_valid && rx_ready && armed && is_marker(rx_word);
endmodule

// File: rtl/ld_span_ctr.sv
module ld_span_ctr
  import linkdly_pkg::*;
#(
  parameter int CNT_W = 32,
  localparam int FINE_W = CNT_W + SLIP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              launch,
  input  logic              stop,
  input  logic [SLIP_W-1:0] slip,
  output logic              running,
  output logic              done,
  output logic              sat,
  output logic [CNT_W-1:0]  coarse,
  output logic [FINE_W-1:0] fine
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]  cnt;
  logic [FINE_W-1:0] cnt_w;
  logic [FINE_W-1:0] fine_nx;

  assign cnt_w   = FINE_W'(cnt);
  assign fine_nx = (cnt_w << 4) + (cnt_w << 2) + FINE_W'(slip);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
      done    <= 1'b0;
      sat     <= 1'b0;
      coarse  <= '0;
      fine    <= '0;
    end else begin
      if (clear) begin
        done <= 1'b0;
        sat  <= 1'b0;
      end
      if (launch) begin
        cnt     <= CNT_W'(1);
        running <= 1'b1;
      end else if (running) begin
        if (stop) begin
          running <= 1'b0;
          done    <= 1'b1;
          coarse  <= cnt;
          fine    <= fine_nx;
        end else if (cnt == CNT_MAX) begin
          sat <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/linkdly_timer.sv
module linkdly_timer
  import linkdly_pkg::*;
#(
  parameter int         CNT_W     = 32,
  parameter logic [7:0] MARK_DATA = 8'h4A,
  localparam int        FINE_W    = CNT_W + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [4:0]        slip_i,
  output logic [15:0]       tx_data,
  output logic [1:0]        tx_isk,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [15:0]       rx_data,
  input  logic [1:0]        rx_isk,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic              busy,
  output logic              done,
  output logic              overflow,
  output logic [CNT_W-1:0]  coarse,
  output logic [FINE_W-1:0] fine
);
  logic  accept;
  logic  mark_sent;
  logic  hit;
  logic  running;
  pair_t tx_word;
  pair_t rx_word;

  assign accept  = start_i && !busy;
  assign tx_data = tx_word.data;
  assign tx_isk  = tx_word.isk;
  assign rx_word = '{isk: rx_isk, data: rx_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy <= 1'b0;
    else if (accept) busy <= 1'b1;
    else if (hit)    busy <= 1'b0;
  end

  ld_tx_gen #(.MARK_DATA(MARK_DATA)) u_tx (
    .clk(clk), .rst_n(rst_n), .arm(accept), .tx_ready(tx_ready),
    .tx_word(tx_word), .tx_valid(tx_valid), .mark_sent(mark_sent)
  );

  ld_rx_det u_rx (
    .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .rx_valid(rx_valid),
    .armed(running), .rx_ready(rx_ready), .hit(hit)
  );

  ld_span_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clear(accept), .launch(mark_sent),
    .stop(hit), .slip(slip_i), .running(running), .done(done),
    .sat(overflow), .coarse(coarse), .fine(fine)
  );
endmodule

// File: rtl/linkdly_chk.sv
module linkdly_chk #(
  parameter int  CNT_W  = 32,
  localparam int FINE_W = CNT_W + 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        slip_i,
  input logic [15:0]       tx_data,
  input logic [1:0]        tx_isk,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_ready,
  input logic              busy,
  input logic              done,
  input logic              overflow,
  input logic [CNT_W-1:0]  coarse,
  input logic [FINE_W-1:0] fine
);
  logic              tx_mark;
  logic [FINE_W-1:0] base;

  assign tx_mark = tx_valid && tx_isk == 2'b01 && tx_data[7:0] == 8'hF7;
  assign base    = (FINE_W'(coarse) << 4) + (FINE_W'(coarse) << 2);

  AST_IDLE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_mark |-> tx_data == 16'h50BC && tx_isk == 2'b01); // R1
  AST_LINK_UP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tx_valid && rx_ready); // R2
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> $stable(tx_data) && $stable(tx_isk)); // R3
  AST_SINGLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    tx_mark && tx_ready |=> !tx_mark); // R4
  AST_COARSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(done) |-> $stable(coarse)); // R6
  AST_FINE_REL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> fine >= base && (fine - base) < FINE_W'(20)); // R7
  AST_SLIP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    slip_i < 5'd20); // R7
  AST_OVF_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    done && overflow |-> &coarse); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy)); // R9
endmodule

bind linkdly_timer linkdly_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slip_i(slip_i), .tx_data(tx_data),
  .tx_isk(tx_isk), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_ready(rx_ready), .busy(busy), .done(done), .overflow(overflow),
  .coarse(coarse), .fine(fine)
);

// File: tb/sim_linkdly_timer.sv
module sim_linkdly_timer;
  localparam int CW = 10;
  localparam int FW = CW + 5;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [4:0]    slip_i = '0;
  logic [15:0]   tx_data;
  logic [1:0]    tx_isk;
  logic          tx_valid;
  logic          tx_ready = 1'b1;
  logic [15:0]   rx_data = '0;
  logic [1:0]    rx_isk = '0;
  logic          rx_valid = 1'b0;
  logic          rx_ready, busy, done, overflow;
  logic [CW-1:0] coarse;
  logic [FW-1:0] fine;

  int n_chk = 0, n_fail = 0;
  int unsigned cyc = 0;
  int dly = 1;
  int mk_tx = 0;
  bit rdy_rand = 0, inj = 0, fin = 0;
  logic [18:0] ring [2048];

  always #10 clk = ~clk;

  linkdly_timer #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .slip_i(slip_i),
    .tx_data(tx_data), .tx_isk(tx_isk), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_isk(rx_isk), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .busy(busy), .done(done), .overflow(overflow), .coarse(coarse), .fine(fine)
  );

  // link model: word handed over at edge c comes back at edge c+dly
  always @(negedge clk) if (rst_n) begin
    logic        rec;
    logic [18:0] ent;
    tx_ready = rdy_rand ? (($urandom % 4) != 0) : 1'b1;
    rec = tx_valid && tx_ready;
    ring[cyc % 2048] = {rec, tx_isk, tx_data};
    if (rec && tx_isk == 2'b01 && tx_data[7:0] == 8'hF7) mk_tx++;
    if (inj) ent = {1'b1, 2'b01, 16'h00F7};
    else if (cyc >= dly) ent = ring[(cyc - dly) % 2048];
    else ent = '0;
    {rx_valid, rx_isk, rx_data} = ent;
    cyc++;
  end

  function automatic longint exp_coarse(input int n);
    return (n > CMAX) ? CMAX : n;
  endfunction

  function automatic longint exp_fine(input int n, input int s);
    return exp_coarse(n) * 20 + s;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic run(input int n, input int s, input bit rnd, input bit dbl);
    int k = 0;
    @(posedge clk);
    foreach (ring[i]) ring[i] = '0;
    dly = n; slip_i = 5'(s); rdy_rand = rnd; mk_tx = 0;
    pulse_start();
    check("R4 busy after start", busy, 1);
    check("R9 done cleared by start", done, 0);
    if (dbl) begin
      repeat (n / 2 + 1) @(negedge clk);
      pulse_start();
    end
    while (!done && k < 4000) begin @(negedge clk); k++; end
    check("R6 coarse", coarse, exp_coarse(n));
    check("R7 fine", fine, exp_fine(n, s));
    check("R8 overflow", overflow, n > CMAX);
    check("R9 busy low when done", busy, 0);
    repeat (4) @(negedge clk);
    if (dbl) check("R5 single marker despite second start", mk_tx, 1);
    else     check("R4 single marker", mk_tx, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    foreach (ring[i]) ring[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 busy reset", busy, 0);
    check("R2 done reset", done, 0);
    check("R2 overflow reset", overflow, 0);
    check("R2 coarse reset", coarse, 0);
    check("R2 fine reset", fine, 0);
    check("R2 tx_valid", tx_valid, 1);
    check("R2 rx_ready", rx_ready, 1);
    check("R1 idle data", tx_data, 16'h50BC);
    check("R1 idle flags", tx_isk, 2'b01);
    // stray marker with no measurement
    inj = 1; repeat (3) @(negedge clk); inj = 0; repeat (2) @(negedge clk);
    check("R6 stray marker before start", done, 0);
    check("R6 stray marker busy", busy, 0);
    // directed corners
    run(1, 0, 0, 0);
    run(7, 19, 0, 0);
    run(40, 5, 1, 0);
    run(60, 11, 0, 1);
    run(CMAX, 3, 0, 0);
    // stray marker while idle after a result
    inj = 1; repeat (3) @(negedge clk); inj = 0; repeat (2) @(negedge clk);
    check("R6 stray marker keeps coarse", coarse, CMAX);
    check("R9 done held", done, 1);
    run(1100, 9, 0, 0);
    run(25, 2, 1, 0);
    check("R8 overflow cleared", overflow, 0);
    // random runs
    for (int r = 0; r < 8; r++) begin
      int n, s;
      n = 1 + int'($urandom % 400);
      s = int'($urandom % 20);
      run(n, s, bit'($urandom % 2), bit'(r == 3));
    end
    fin = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule